// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the architectural state change that happens when a processor core takes an exception. The core presents the address of the current instruction, its present machine state register (MSR) value, the fault address, and a request vector with one line per exception cause. Small cause codes describe storage faults and program exceptions.

In the cycle a request is accepted, the unit works out several results. It forces a set of mode bits in the MSR and saves the return address and a masked copy of the old MSR, together with cause bits. It updates the fault-address and fault-status registers when the cause calls for it. It forms the redirect fetch address from the vector base and the vector offset of the winning cause.

All of these become visible together on the following cycle, with a one-cycle redirect pulse. In that same cycle the unit drops `ready` and ignores any request. A flag marks an exception that was taken while the old MSR said the machine state was not recoverable. Bit positions below count from the least significant bit (bit 0). MSR, return address and fault address are 64 bits wide; the fault-status word is 32 bits wide.

Top module: `exc_entry_unit`

## Requirements
- R1: On acceptance, the new MSR is the old MSR with these bits cleared: 18 (power management), 15 (external enable), 14 (problem state), 13 (FP available), 11 and 8 (FP exception modes), 10 (single step), 9 (branch trace), 5 (instruction relocate), 4 (data relocate), 1 (recoverable). Bit 63 (64-bit mode) is set and every other bit is kept.
- R2: On acceptance, the saved status holds old MSR bits 63:31, 26:22 and 15:0, with all other bits zero except the cause bits of R9.
- R3: On acceptance, the saved return address is the current instruction address. For a system call (request bit 6) it is that address plus 4.
- R4: The redirect address is the vector offset ORed with a base. The base is 0xFFFF_FFFF_FFF0_0000 when bit 6 of the new MSR is set, and zero otherwise.
- R5: Request bits 0..9 select the causes machine check, instruction storage, data storage, alignment, program, FP unavailable, system call, FP assist, external and decrementer. Their offsets are 0x200, 0x400, 0x300, 0x600, 0x700, 0x800, 0xC00, 0xE00, 0x500 and 0x900 respectively.
- R6: When several request bits are set, the lowest-numbered bit wins, so machine check has the highest priority. The other requests are dropped.
- R7: `doubleFault` pulses together with `redirect` exactly when bit 1 of the old MSR was clear at acceptance. At all other times it is low.
- R8: A data storage fault loads the fault address into `dar`. It loads `dsisr` with one cause bit chosen by `dsCause`: 0 sets bit 31, 1 sets bit 30, 2 sets bit 27, 3 sets bit 21, 4 sets bit 26, 5 sets bit 20, and 6 or 7 set no bit. Bit 25 is ORed in when `dsStore` is high.
- R9: An instruction storage fault sets one saved-status bit chosen by `isCause` (0→30, 1→28, 2→27, 3→21). A program exception sets one bit chosen by `progCause` (0→20, 1→19, 2→18, 3→17). No other cause sets any of these bits.
- R10: An alignment fault loads the fault address into `dar` and writes zero to `dsisr`.
- R11: Results appear one cycle after acceptance, with a `redirect` pulse exactly one cycle long. `ready` is low in that cycle, and a request made while `ready` is low leaves every output unchanged.
- R12: After reset, all register outputs are zero, `redirect` and `doubleFault` are low, and `ready` is high.
- R13: Causes other than data storage and alignment leave `dar` and `dsisr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqVec | input | 10 | Exception request lines, bit index is cause and priority |
| curPc | input | 64 | Address of the current instruction |
| curMsr | input | 64 | Present MSR value |
| faultAddr | input | 64 | Effective address of a storage or alignment fault |
| dsCause | input | 3 | Data storage fault cause code |
| dsStore | input | 1 | Faulting data access was a store |
| isCause | input | 2 | Instruction storage fault cause code |
| progCause | input | 2 | Program exception cause code |
| ready | output | 1 | Unit can accept a request this cycle |
| redirect | output | 1 | One-cycle pulse: outputs hold a new exception entry |
| nextPc | output | 64 | Redirect fetch address |
| newMsr | output | 64 | MSR value to install |
| srr0 | output | 64 | Saved return address |
| srr1 | output | 64 | Saved status |
| dar | output | 64 | Fault address register |
| dsisr | output | 32 | Fault status register |
| doubleFault | output | 1 | Exception taken while not recoverable |

## Verification
A wrong priority pick or a stale result shows at the ports on the cycle after acceptance. It appears as a redirect address with the wrong offset, or a saved status carrying the wrong cause bit. A mistake in the ready/redirect state shows one cycle later. It appears either as a second pulse or as a request accepted during the blocked cycle, which overwrites the saved registers. Each clock cycle, a behavioural model compares every output against its own expected value. A fault therefore surfaces at the first edge where it changes a port.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int XLEN        = 64;
  localparam int DSISR_W     = 32;
  localparam int NUM_CAUSE   = 10;
  localparam int DS_CODE_W   = 3;
  localparam int IS_CODE_W   = 2;
  localparam int PROG_CODE_W = 2;
  localparam int OFF_W       = 12;
  localparam int VEC_LOW_W   = 20;

  // cause indices: position in the request vector is also priority
  localparam int C_MCHK    = 0;
  localparam int C_ISI     = 1;
  localparam int C_DSI     = 2;
  localparam int C_ALIGN   = 3;
  localparam int C_PROG    = 4;
  localparam int C_FPUNAV  = 5;
  localparam int C_SYSCALL = 6;
  localparam int C_FPASST  = 7;
  localparam int C_EXT     = 8;
  localparam int C_DEC     = 9;

  // MSR bit positions, lsb = 0
  localparam int MSR_SF  = 63;
  localparam int MSR_POW = 18;
  localparam int MSR_EE  = 15;
  localparam int MSR_PR  = 14;
  localparam int MSR_FP  = 13;
  localparam int MSR_FE0 = 11;
  localparam int MSR_SE  = 10;
  localparam int MSR_BE  = 9;
  localparam int MSR_FE1 = 8;
  localparam int MSR_IP  = 6;
  localparam int MSR_IR  = 5;
  localparam int MSR_DR  = 4;
  localparam int MSR_RI  = 1;

  localparam int DSISR_STORE = 25;

  typedef struct packed {
    logic                 take;
    logic [NUM_CAUSE-1:0] grant;
  } exc_strobe_t;

  function automatic logic [XLEN-1:0] bitAt(input int pos);
    logic [XLEN-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] modeClearMask();
    return bitAt(MSR_POW) | bitAt(MSR_EE) | bitAt(MSR_PR) | bitAt(MSR_FP)
         | bitAt(MSR_FE0) | bitAt(MSR_SE) | bitAt(MSR_BE) | bitAt(MSR_FE1)
         | bitAt(MSR_IR) | bitAt(MSR_DR) | bitAt(MSR_RI);
  endfunction

  function automatic logic [XLEN-1:0] statusKeepMask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (i >= 31 || (i >= 22 && i <= 26) || i <= 15) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [XLEN-1:0] MODE_CLEAR  = modeClearMask();
  localparam logic [XLEN-1:0] STATUS_KEEP = statusKeepMask();
  localparam logic [XLEN-1:0] VEC_BASE    = {{(XLEN-VEC_LOW_W){1'b1}}, {VEC_LOW_W{1'b0}}};

  function automatic logic [OFF_W-1:0] causeOffset(input int idx);
    case (idx)
      C_MCHK:    return 12'h200;
      C_ISI:     return 12'h400;
      C_DSI:     return 12'h300;
      C_ALIGN:   return 12'h600;
      C_PROG:    return 12'h700;
      C_FPUNAV:  return 12'h800;
      C_SYSCALL: return 12'hC00;
      C_FPASST:  return 12'hE00;
      C_EXT:     return 12'h500;
      C_DEC:     return 12'h900;
      default:   return 12'h000;
    endcase
  endfunction

  function automatic logic [DSISR_W-1:0] dataFaultBit(input logic [DS_CODE_W-1:0] code);
    logic [DSISR_W-1:0] v;
    v = '0;
    case (code)
      3'd0: v[31] = 1'b1;
      3'd1: v[30] = 1'b1;
      3'd2: v[27] = 1'b1;
      3'd3: v[21] = 1'b1;
      3'd4: v[26] = 1'b1;
      3'd5: v[20] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [XLEN-1:0] fetchFaultBit(input logic [IS_CODE_W-1:0] code);
    case (code)
      2'd0: return bitAt(30);
      2'd1: return bitAt(28);
      2'd2: return bitAt(27);
      default: return bitAt(21);
    endcase
  endfunction

  function automatic logic [XLEN-1:0] progFaultBit(input logic [PROG_CODE_W-1:0] code);
    case (code)
      2'd0: return bitAt(20);
      2'd1: return bitAt(19);
      2'd2: return bitAt(18);
      default: return bitAt(17);
    endcase
  endfunction

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CAUSE-1:0] reqVec,
  output exc_strobe_t          strobe,
  output logic                 ready,
  output logic                 redirect
);

  logic [NUM_CAUSE-1:0] grantRaw;
  logic [NUM_CAUSE:0]   seenLower;

  // fixed priority: lowest index wins
  assign seenLower[0] = 1'b0;
  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_prio
    assign grantRaw[g]      = reqVec[g] & ~seenLower[g];
    assign seenLower[g + 1] = seenLower[g] | reqVec[g];
  end

  assign ready        = ~redirect;
  assign strobe.take  = ready & seenLower[NUM_CAUSE];
  assign strobe.grant = ready ? grantRaw : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) redirect <= 1'b0;
    else       redirect <= strobe.take;
  end

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  exc_strobe_t            strobe,
  input  logic [XLEN-1:0]        curPc,
  input  logic [XLEN-1:0]        curMsr,
  input  logic [XLEN-1:0]        faultAddr,
  input  logic [DS_CODE_W-1:0]   dsCause,
  input  logic                   dsStore,
  input  logic [IS_CODE_W-1:0]   isCause,
  input  logic [PROG_CODE_W-1:0] progCause,
  output logic [XLEN-1:0]        nextPc,
  output logic [XLEN-1:0]        newMsr,
  output logic [XLEN-1:0]        srr0,
  output logic [XLEN-1:0]        srr1,
  output logic [XLEN-1:0]        dar,
  output logic [DSISR_W-1:0]     dsisr,
  output logic                   doubleFault
);

  logic [OFF_W-1:0]     offTerm [NUM_CAUSE];
  logic [OFF_W-1:0]     vecOff;
  logic [XLEN-1:0]      msrNext;
  logic [XLEN-1:0]      causeSet;
  logic [XLEN-1:0]      srr1Next;
  logic [XLEN-1:0]      srr0Next;
  logic [XLEN-1:0]      pcNext;
  logic [DSISR_W-1:0]   dsisrNext;
  logic                 faultWr;

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_off
    assign offTerm[g] = strobe.grant[g] ? causeOffset(g) : '0;
  end

  always_comb begin
    vecOff = '0;
    for (int i = 0; i < NUM_CAUSE; i++) vecOff |= offTerm[i];
  end

  assign msrNext = (curMsr & ~MODE_CLEAR) | bitAt(MSR_SF);

  always_comb begin
    causeSet = '0;
    if (strobe.grant[C_ISI])  causeSet = fetchFaultBit(isCause);
    if (strobe.grant[C_PROG]) causeSet = progFaultBit(progCause);
  end

  assign srr1Next = (curMsr & STATUS_KEEP) | causeSet;
  assign srr0Next = strobe.grant[C_SYSCALL] ? curPc + XLEN'(4) : curPc;
  // low base bits are zero and offsets fit below them, so OR forms the sum
  assign pcNext   = (msrNext[MSR_IP] ? VEC_BASE : '0) | {{(XLEN-OFF_W){1'b0}}, vecOff};

  always_comb begin
    dsisrNext = '0;
    if (strobe.grant[C_DSI]) begin
      dsisrNext = dataFaultBit(dsCause);
      dsisrNext[DSISR_STORE] = dsStore;
    end
  end

  assign faultWr = strobe.grant[C_DSI] | strobe.grant[C_ALIGN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc      <= '0;
      newMsr      <= '0;
      srr0        <= '0;
      srr1        <= '0;
      dar         <= '0;
      dsisr       <= '0;
      doubleFault <= 1'b0;
    end else begin
      doubleFault <= strobe.take & ~curMsr[MSR_RI];
      if (strobe.take) begin
        nextPc <= pcNext;
        newMsr <= msrNext;
        srr0   <= srr0Next;
        srr1   <= srr1Next;
      end
      if (faultWr) begin
        dar   <= faultAddr;
        dsisr <= dsisrNext;
      end
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CAUSE-1:0]   reqVec,
  input  logic [XLEN-1:0]        curPc,
  input  logic [XLEN-1:0]        curMsr,
  input  logic [XLEN-1:0]        faultAddr,
  input  logic [DS_CODE_W-1:0]   dsCause,
  input  logic                   dsStore,
  input  logic [IS_CODE_W-1:0]   isCause,
  input  logic [PROG_CODE_W-1:0] progCause,
  output logic                   ready,
  output logic                   redirect,
  output logic [XLEN-1:0]        nextPc,
  output logic [XLEN-1:0]        newMsr,
  output logic [XLEN-1:0]        srr0,
  output logic [XLEN-1:0]        srr1,
  output logic [XLEN-1:0]        dar,
  output logic [DSISR_W-1:0]     dsisr,
  output logic                   doubleFault
);

  exc_strobe_t strobe;

  exc_entry_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .strobe   (strobe),
    .ready    (ready),
    .redirect (redirect)
  );

  exc_entry_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .curPc       (curPc),
    .curMsr      (curMsr),
    .faultAddr   (faultAddr),
    .dsCause     (dsCause),
    .dsStore     (dsStore),
    .isCause     (isCause),
    .progCause   (progCause),
    .nextPc      (nextPc),
    .newMsr      (newMsr),
    .srr0        (srr0),
    .srr1        (srr1),
    .dar         (dar),
    .dsisr       (dsisr),
    .doubleFault (doubleFault)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CAUSE-1:0] reqVec,
  input logic [XLEN-1:0]      curMsr,
  input logic                 ready,
  input logic                 redirect,
  input logic [XLEN-1:0]      nextPc,
  input logic [XLEN-1:0]      newMsr,
  input logic [XLEN-1:0]      srr0,
  input logic [XLEN-1:0]      srr1,
  input logic                 doubleFault
);

  a_r11_accept_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (ready && |reqVec) |=> (redirect && !ready));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);

  a_r11_blocked_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ($stable(srr0) && $stable(srr1) && $stable(newMsr)));

  a_r1_mode_forced: assert property (@(posedge clk) disable iff (!rstN)
    (ready && |reqVec) |=> (newMsr[MSR_SF] && !newMsr[MSR_EE] && !newMsr[MSR_PR] && !newMsr[MSR_RI]));

  a_r2_status_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ready && |reqVec) |=> ((srr1 & STATUS_KEEP) == ($past(curMsr) & STATUS_KEEP)));

  a_r7_double_flag: assert property (@(posedge clk) disable iff (!rstN)
    (ready && |reqVec) |=> (doubleFault == !$past(curMsr[MSR_RI])));

  a_r7_flag_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !redirect |-> !doubleFault);

  a_r5_vector_aligned: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (nextPc[7:0] == 8'h00));

  a_r6_mchk_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqVec[C_MCHK]) |=> (nextPc[VEC_LOW_W-1:0] == 20'h00200));

endmodule

bind exc_entry_unit exc_entry_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqVec      (reqVec),
  .curMsr      (curMsr),
  .ready       (ready),
  .redirect    (redirect),
  .nextPc      (nextPc),
  .newMsr      (newMsr),
  .srr0        (srr0),
  .srr1        (srr1),
  .doubleFault (doubleFault)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  reqVec = '0;
  logic [63:0] curPc = '0, curMsr = '0, faultAddr = '0;
  logic [2:0]  dsCause = '0;
  logic        dsStore = 1'b0;
  logic [1:0]  isCause = '0, progCause = '0;
  logic        ready, redirect, doubleFault;
  logic [63:0] nextPc, newMsr, srr0, srr1, dar;
  logic [31:0] dsisr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic        mRedir = 1'b0, mDf = 1'b0;
  logic [63:0] mPc = '0, mMsr = '0, mSrr0 = '0, mSrr1 = '0, mDar = '0;
  logic [31:0] mDsisr = '0;

  always #4 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .curPc(curPc), .curMsr(curMsr),
    .faultAddr(faultAddr), .dsCause(dsCause), .dsStore(dsStore), .isCause(isCause),
    .progCause(progCause), .ready(ready), .redirect(redirect), .nextPc(nextPc),
    .newMsr(newMsr), .srr0(srr0), .srr1(srr1), .dar(dar), .dsisr(dsisr),
    .doubleFault(doubleFault)
  );

  function automatic logic [63:0] b64(input int n);
    return 64'h1 << n;
  endfunction

  function automatic logic [11:0] offsetOf(input int c);
    logic [11:0] tbl [10] = '{12'h200, 12'h400, 12'h300, 12'h600, 12'h700,
                              12'h800, 12'hC00, 12'hE00, 12'h500, 12'h900};
    return tbl[c];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    int win;
    logic [63:0] keep, clr;
    if (!mRedir && reqVec != 0) begin
      win = 0;
      while (!reqVec[win]) win++;
      clr = b64(18) | b64(15) | b64(14) | b64(13) | b64(11) | b64(8)
          | b64(10) | b64(9) | b64(5) | b64(4) | b64(1);
      keep = '0;
      for (int i = 0; i < 64; i++) if (i >= 31 || (i >= 22 && i <= 26) || i <= 15) keep[i] = 1'b1;
      mMsr  = (curMsr & ~clr) | b64(63);
      mSrr1 = curMsr & keep;
      if (win == 1) mSrr1 |= b64((isCause == 0) ? 30 : (isCause == 1) ? 28 : (isCause == 2) ? 27 : 21);
      if (win == 4) mSrr1 |= b64(20 - int'(progCause));
      mSrr0 = (win == 6) ? curPc + 64'd4 : curPc;
      mPc   = (mMsr[6] ? 64'hFFFF_FFFF_FFF0_0000 : 64'h0) + {52'h0, offsetOf(win)};
      mDf   = !curMsr[1];
      if (win == 2) begin
        mDar = faultAddr;
        case (dsCause)
          3'd0: mDsisr = 32'h8000_0000;
          3'd1: mDsisr = 32'h4000_0000;
          3'd2: mDsisr = 32'h0800_0000;
          3'd3: mDsisr = 32'h0020_0000;
          3'd4: mDsisr = 32'h0400_0000;
          3'd5: mDsisr = 32'h0010_0000;
          default: mDsisr = 32'h0;
        endcase
        if (dsStore) mDsisr |= 32'h0200_0000;
      end
      if (win == 3) begin
        mDar = faultAddr;
        mDsisr = 32'h0;
      end
      mRedir = 1'b1;
    end else begin
      mRedir = 1'b0;
      mDf = 1'b0;
    end
  endtask

  task automatic compareAll();
    chk("R11 redirect", {63'h0, redirect}, {63'h0, mRedir});
    chk("R11 ready", {63'h0, ready}, {63'h0, !mRedir});
    chk("R1 newMsr", newMsr, mMsr);
    chk("R2 srr1", srr1, mSrr1);
    chk("R3 srr0", srr0, mSrr0);
    chk("R4 nextPc", nextPc, mPc);
    chk("R8 dar", dar, mDar);
    chk("R8 dsisr", {32'h0, dsisr}, {32'h0, mDsisr});
    chk("R7 doubleFault", {63'h0, doubleFault}, {63'h0, mDf});
  endtask

  task automatic step(input logic [9:0] rq, input logic [63:0] pc, input logic [63:0] msr,
                      input logic [63:0] fa, input logic [2:0] dc, input logic ds,
                      input logic [1:0] ic, input logic [1:0] pcg);
    reqVec = rq; curPc = pc; curMsr = msr; faultAddr = fa;
    dsCause = dc; dsStore = ds; isCause = ic; progCause = pcg;
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    step(10'h0, 64'h0, 64'h0, 64'h0, 3'd0, 1'b0, 2'd0, 2'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [63:0] keepDar;
    repeat (3) @(negedge clk);
    // R12: reset values
    chk("R12 ready", {63'h0, ready}, 64'h1);
    chk("R12 redirect", {63'h0, redirect}, 64'h0);
    chk("R12 regs", nextPc | newMsr | srr0 | srr1 | dar | {32'h0, dsisr}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: every cause alone
    for (int c = 0; c < 10; c++) begin
      step(10'h1 << c, 64'h1000 + 64'(c * 16), 64'h2, 64'h0, 3'd0, 1'b0, 2'd0, 2'd0);
      chk("R5 offset", nextPc, {52'h0, offsetOf(c)});
      idle();
    end

    // R6: all requests at once, machine check wins
    step(10'h3FF, 64'h2000, 64'h2, 64'hAB, 3'd1, 1'b0, 2'd1, 2'd1);
    chk("R6 mchk wins", nextPc, 64'h200);
    chk("R6 no cause bits", srr1 & 64'h7FFF_FFFF, 64'h2);
    idle();
    step(10'h300, 64'h2100, 64'h2, 64'h0, 3'd0, 1'b0, 2'd0, 2'd0);
    chk("R6 external over decrementer", nextPc, 64'h500);
    idle();

    // R4: prefix bit set
    step(10'h10, 64'h2200, 64'h42, 64'h0, 3'd0, 1'b0, 2'd0, 2'd3);
    chk("R4 high base", nextPc, 64'hFFFF_FFFF_FFF0_0700);
    chk("R9 trap bit", srr1 & b64(17), b64(17));
    idle();

    // R9: instruction storage protection
    step(10'h2, 64'h2300, 64'h2, 64'h0, 3'd0, 1'b0, 2'd2, 2'd0);
    chk("R9 protection bit", srr1 & 64'h7FFF_FFFF, b64(27) | 64'h2);
    idle();

    // R3: system call
    step(10'h40, 64'h4000, 64'h2, 64'h0, 3'd0, 1'b0, 2'd0, 2'd0);
    chk("R3 syscall plus four", srr0, 64'h4004);
    idle();

    // R7: not recoverable
    step(10'h100, 64'h4100, 64'h0, 64'h0, 3'd0, 1'b0, 2'd0, 2'd0);
    chk("R7 double flag", {63'h0, doubleFault}, 64'h1);
    idle();

    // R8 then R10 then R13
    step(10'h4, 64'h5000, 64'h2, 64'hDEAD_0000, 3'd2, 1'b1, 2'd0, 2'd0);
    chk("R8 dsisr store+prot", {32'h0, dsisr}, 64'h0A00_0000);
    idle();
    step(10'h8, 64'h5100, 64'h2, 64'hBEEF_0001, 3'd0, 1'b0, 2'd0, 2'd0);
    chk("R10 dsisr zero", {32'h0, dsisr}, 64'h0);
    chk("R10 dar", dar, 64'hBEEF_0001);
    idle();
    keepDar = dar;
    step(10'h200, 64'h5200, 64'h2, 64'h1234, 3'd1, 1'b1, 2'd0, 2'd0);
    chk("R13 dar kept", dar, keepDar);
    idle();

    // R11: back-to-back request, second ignored
    step(10'h20, 64'h6000, 64'h2, 64'h0, 3'd0, 1'b0, 2'd0, 2'd0);
    step(10'h1, 64'h6100, 64'h2, 64'h0, 3'd0, 1'b0, 2'd0, 2'd0);
    chk("R11 blocked request ignored", srr0, 64'h6000);
    idle();

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [9:0] rq;
      rq = ($urandom % 3 == 0) ? 10'h0 : 10'($urandom) & 10'($urandom);
      step(rq, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
           3'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule